// File: doc/BRIEF.md
# Link Training State Monitor

This block sits beside a PCIe core and decides whether the link is usable. It takes the core's status word, keeps the low five bits as the training state code, and treats only three codes as operational: 0x11 (L0), 0x12 (L0s) and 0x14 (L1 idle). Every other code counts as down, including the two L2 codes (0x15 idle, 0x16 wake). Software cannot bring the link out of L2 on its own, so a link in L2 is not reported as up.

A check starts with a one-cycle request strobe. The block samples the state once straight away. If the link is already up, it reports completion at once, without waiting for a tick. If not, it samples the state again on each millisecond tick. The request edge and the decision are one clock apart, because the decision is registered. The budget is a fixed number of ticks, 120 by default. When the budget runs out, the block reports a timeout and does not sample the state at the final tick. Each check ends with a single-cycle done pulse. The link-up and timeout results then stay as they are until the next request is accepted. The block does not take part in training the link.

Top module: `link_watch`

## Requirements
- R1: After reset, link_up_o, done_o and timeout_o are all low.
- R2: Only bits [4:0] of ltssm_word_i form the state code. The upper bits have no effect on any result.
- R3: The link is classed as up only when the state code is 0x11, 0x12 or 0x14.
- R4: The codes 0x15 and 0x16 (L2), 0x00 (detect quiet), 0x19 (disabled) and 0x1F (hot reset) are classed as down, like every code not listed in R3.
- R5: A request is sampled at a rising edge. If the state is up at the next rising edge, done_o and link_up_o go high after that edge, and no tick is needed.
- R6: Once the first sample is down, the state is re-sampled only at an edge where ms_tick_i is high. A change to an up code between ticks produces no result until the next tick.
- R7: At the edge of the TICK_LIMIT-th tick (default 120) after a down first sample, the check ends with done_o and timeout_o high and link_up_o low. The state at that tick is not examined.
- R8: done_o is high for exactly one cycle per completed check.
- R9: link_up_o and timeout_o keep their values after a check ends, whatever the state or ticks do. Both are cleared at the edge that accepts the next request.
- R10: A request that arrives while a check is in progress is ignored. It neither restarts the check nor resets the tick budget.
- R11: link_up_o and timeout_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ltssm_word_i | input | STATUS_W (32) | Status word from the PCIe core; bits [4:0] hold the training state |
| check_req_i | input | 1 | Strobe that starts a check when the block is idle |
| ms_tick_i | input | 1 | One-cycle strobe per millisecond interval |
| link_up_o | output | 1 | Last check found the link operational |
| done_o | output | 1 | One-cycle pulse when a check ends |
| timeout_o | output | 1 | Last check ran out of its tick budget |

## Verification
The embedded assertions check the following on every cycle:
- done is a single-cycle pulse.
- The two results are mutually exclusive.
- Link-up rises only after the decoder saw an operational code.
- Timeout rises only on the counter's terminal tick.
- The results hold steady while idle.
- A completion never appears in the waiting phase without a tick.
- The tick counter stays within its budget.
- The L2 codes never decode as up.

Other behaviours can only be shown by the directed scenarios, because they depend on exact counts and on what the design ignores:
- The full sweep of all 32 codes.
- The exact tick on which the timeout lands.
- The final tick going unexamined.
- Upper status bits being ignored.
- A request during a check being dropped.

// File: rtl/lkmon_pkg.sv
package lkmon_pkg;

  localparam int unsigned CODE_W = 5;

  localparam logic [CODE_W-1:0] CODE_L0       = 5'h11;
  localparam logic [CODE_W-1:0] CODE_L0S      = 5'h12;
  localparam logic [CODE_W-1:0] CODE_L1_IDLE  = 5'h14;
  localparam logic [CODE_W-1:0] CODE_L2_IDLE  = 5'h15;
  localparam logic [CODE_W-1:0] CODE_L2_WAKE  = 5'h16;

  typedef enum logic [1:0] {
    CHK_IDLE  = 2'd0,
    CHK_FIRST = 2'd1,
    CHK_WAIT  = 2'd2
  } chk_state_e;

  function automatic logic code_is_up(input logic [CODE_W-1:0] code);
    return (code == CODE_L0) || (code == CODE_L0S) || (code == CODE_L1_IDLE);
  endfunction

endpackage

// File: rtl/lkmon_rst_sync.sv
module lkmon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lkmon_decode.sv
module lkmon_decode
  import lkmon_pkg::*;
#(
  parameter int unsigned STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STATUS_W-1:0] word_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                up_o
);

  // Only the low field carries the training state.
  assign code_o = word_i[CODE_W-1:0];
  assign up_o   = code_is_up(code_o);

  AST_L2_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ((word_i[CODE_W-1:0] == CODE_L2_IDLE) || (word_i[CODE_W-1:0] == CODE_L2_WAKE)) |-> !up_o)
    else $error("L2 code classed as up"); // R4

endmodule

// File: rtl/lkmon_interval.sv
module lkmon_interval #(
  parameter int unsigned TICK_LIMIT = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);

  localparam int unsigned CNT_W = $clog2(TICK_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TICK_LIMIT);
  localparam logic [CNT_W-1:0] CNT_TERM = CNT_W'(TICK_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (en_i && (cnt_q != CNT_MAX));
    cnt_d  = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (en_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = en_i && !clr_i && (cnt_q == CNT_TERM);

  AST_CNT_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX)
    else $error("interval count beyond budget"); // R7

  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0))
    else $error("count not restarted"); // R10

endmodule

// File: rtl/lkmon_fsm.sv
module lkmon_fsm
  import lkmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic tick_i,
  input  logic up_i,
  input  logic last_i,
  output logic cnt_clr_o,
  output logic cnt_en_o,
  output logic link_up_o,
  output logic done_o,
  output logic timeout_o
);

  chk_state_e state_q, state_d;
  logic       up_q, up_d;
  logic       to_q, to_d;
  logic       done_q, done_d;
  logic       res_en;

  assign cnt_clr_o = (state_q == CHK_IDLE) && req_i;
  assign cnt_en_o  = (state_q == CHK_WAIT) && tick_i;

  always_comb begin
    state_d = state_q;
    up_d    = up_q;
    to_d    = to_q;
    done_d  = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      CHK_IDLE: begin
        if (req_i) begin
          state_d = CHK_FIRST;
          up_d    = 1'b0;
          to_d    = 1'b0;
          res_en  = 1'b1;
        end
      end
      CHK_FIRST: begin
        if (up_i) begin
          state_d = CHK_IDLE;
          up_d    = 1'b1;
          done_d  = 1'b1;
          res_en  = 1'b1;
        end else begin
          state_d = CHK_WAIT;
        end
      end
      CHK_WAIT: begin
        if (tick_i) begin
          if (last_i) begin
            state_d = CHK_IDLE;
            to_d    = 1'b1;
            done_d  = 1'b1;
            res_en  = 1'b1;
          end else if (up_i) begin
            state_d = CHK_IDLE;
            up_d    = 1'b1;
            done_d  = 1'b1;
            res_en  = 1'b1;
          end
        end
      end
      default: begin
        state_d = CHK_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CHK_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      to_q <= 1'b0;
    end else if (res_en) begin
      up_q <= up_d;
      to_q <= to_d;
    end
  end

  assign link_up_o = up_q;
  assign timeout_o = to_q;
  assign done_o    = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done longer than one cycle"); // R8

  AST_RESULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && to_q))
    else $error("link up and timeout together"); // R11

  AST_UP_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(up_i))
    else $error("link up without operational code"); // R3

  AST_TIMEOUT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(last_i))
    else $error("timeout before budget spent"); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CHK_IDLE) && !req_i) |=> ($stable(up_q) && $stable(to_q)))
    else $error("result changed while idle"); // R9

  AST_WAIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CHK_WAIT) && !tick_i) |=> !done_q)
    else $error("completion without tick"); // R6

endmodule

// File: rtl/link_watch.sv
module link_watch
  import lkmon_pkg::*;
#(
  parameter int unsigned STATUS_W    = 32,
  parameter int unsigned TICK_LIMIT  = 120,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STATUS_W-1:0] ltssm_word_i,
  input  logic                check_req_i,
  input  logic                ms_tick_i,
  output logic                link_up_o,
  output logic                done_o,
  output logic                timeout_o
);

  logic              rst_n_sync;
  logic [CODE_W-1:0] code;
  logic              code_up;
  logic              cnt_clr;
  logic              cnt_en;
  logic              cnt_last;

  lkmon_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lkmon_decode #(
    .STATUS_W (STATUS_W)
  ) i_decode (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .word_i (ltssm_word_i),
    .code_o (code),
    .up_o   (code_up)
  );

  lkmon_interval #(
    .TICK_LIMIT (TICK_LIMIT)
  ) i_interval (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .last_o (cnt_last)
  );

  lkmon_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .req_i     (check_req_i),
    .tick_i    (ms_tick_i),
    .up_i      (code_up),
    .last_i    (cnt_last),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .link_up_o (link_up_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
  );

  AST_NO_RESULT_IN_RESET: assert property (@(posedge clk)
    !rst_n_sync |=> (!link_up_o && !done_o && !timeout_o))
    else $error("outputs active around reset"); // R1

  AST_DECODE_FIELD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    code == ltssm_word_i[CODE_W-1:0])
    else $error("state field misaligned"); // R2

endmodule

// File: tb/test_link_watch.sv
module test_link_watch;

  localparam int LIMIT = 120;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] word;
  logic        req;
  logic        tick;
  logic        up;
  logic        done;
  logic        to;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  link_watch i_link_watch (
    .clk          (clk),
    .rst_n        (rst_n),
    .ltssm_word_i (word),
    .check_req_i  (req),
    .ms_tick_i    (tick),
    .link_up_o    (up),
    .done_o       (done),
    .timeout_o    (to)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit up_code(input int c);
    return (c == 'h11) || (c == 'h12) || (c == 'h14);
  endfunction

  task automatic start_check();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // Holds the tick high until done; returns number of ticks consumed.
  task automatic run_to_end(output int n);
    n = 0;
    @(negedge clk) tick = 1'b1;
    for (int i = 1; i <= LIMIT + 5; i++) begin
      @(negedge clk);
      if (done) begin
        n = i;
        break;
      end
    end
    tick = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; word = '0; req = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    chk(!up && !done && !to, "R1 in reset", {up, done, to}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!up && !done && !to, "R1 after reset", {up, done, to}, 0);
  endtask

  task automatic t_immediate(input logic [26:0] hi, input logic [4:0] c);
    word = {hi, c};
    start_check();
    chk(!up && !to, "R9 cleared on accept", {up, to}, 0);
    @(negedge clk);
    chk(done == 1'b1, "R5 immediate done", done, 1);
    chk(up == 1'b1 && to == 1'b0, "R3 up code", {up, to}, 2);
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", done, 0);
    chk(up == 1'b1, "R9 up held", up, 1);
  endtask

  task automatic t_sweep();
    int n;
    for (int c = 0; c < 32; c++) begin
      word = 32'(c);
      start_check();
      @(negedge clk);
      chk(done == up_code(c), $sformatf("R3 R4 code %0h first sample", c), done, up_code(c));
      if (!up_code(c)) begin
        run_to_end(n);
        chk(n == LIMIT && to && !up, $sformatf("R4 R7 code %0h timeout", c), n, LIMIT);
      end
    end
  endtask

  task automatic t_tick_only();
    word = 32'h15;
    start_check();
    @(negedge clk);
    chk(!done && !up, "R4 L2 idle down", {done, up}, 0);
    word = 32'h16; tick_once();
    chk(!done, "R4 L2 wake down", done, 0);
    word = 32'h19; tick_once();
    chk(!done, "R4 disabled down", done, 0);
    word = 32'h1F; tick_once();
    chk(!done, "R4 hot reset down", done, 0);
    word = 32'h11;
    repeat (6) @(negedge clk);
    chk(!done && !up, "R6 no sample without tick", {done, up}, 0);
    tick_once();
    chk(done && up && !to, "R6 sampled on tick", {done, up, to}, 6);
  endtask

  task automatic t_last_tick();
    int early = 0;
    word = 32'h00;
    start_check();
    @(negedge clk);
    for (int i = 0; i < LIMIT - 1; i++) begin
      tick_once();
      if (done) early++;
    end
    chk(early == 0, "R7 no end before limit", early, 0);
    word = 32'h14;
    tick_once();
    chk(done && to && !up, "R7 last tick not examined", {done, up, to}, 5);
    word = 32'h11;
    repeat (3) tick_once();
    @(negedge clk);
    chk(to && !up && !done, "R9 timeout held", {done, up, to}, 1);
    word = 32'h00;
    start_check();
    chk(!to && !up, "R9 timeout cleared on accept", {up, to}, 0);
    run_to_end(early);
  endtask

  task automatic t_ignore_req();
    int n;
    word = 32'h00;
    start_check();
    @(negedge clk);
    repeat (3) tick_once();
    @(negedge clk) begin req = 1'b1; word = 32'h11; end
    @(negedge clk) req = 1'b0;
    @(negedge clk);
    chk(!done && !up, "R10 busy request ignored", {done, up}, 0);
    word = 32'h00;
    run_to_end(n);
    chk(n == LIMIT - 3 && to, "R10 budget not restarted", n, LIMIT - 3);
  endtask

  task automatic t_upper_bits();
    int n;
    word = {27'h7FFFFFF, 5'h15};
    start_check();
    @(negedge clk);
    chk(!done, "R2 upper bits ignored for down code", done, 0);
    run_to_end(n);
    chk(to && !up, "R2 down code times out", {up, to}, 1);
    t_immediate(27'h5A5A5A5, 5'h12);
  endtask

  initial begin
    t_reset();
    t_immediate(27'h0, 5'h11);
    t_immediate(27'h1234567, 5'h12);
    t_immediate(27'h7FFFFFF, 5'h14);
    t_sweep();
    t_tick_only();
    t_last_tick();
    t_ignore_req();
    t_upper_bits();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule